// File: doc/BRIEF.md
# Implicit Im2col Address Generator

This block drives the read side of a DMA engine that feeds a GEMM engine with convolution input. It does not build the expanded im2col matrix in memory. It works out every source address from index arithmetic while the load is running. Each convolution window becomes one column of the logical GEMM operand. Inside a window, addresses come out channel by channel, and within a channel row by row across the kernel. Because nothing is expanded, the working set never grows past one tile, and a tile is at most 32 columns by 32 channels.

Software sets up the job in one cycle with a start pulse, which carries the following:
- the feature-map geometry (height, width, channel count);
- the square kernel size, the stride and the zero-padding;
- the output row;
- a column range and a channel range that together form the tile.

The block then presents one address per cycle on a valid/ready handshake. It flags any position that falls outside the feature map so the data path can insert a zero in place of a memory read. A one-cycle done pulse follows the last accepted address.

Top module: `im2col_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid_o and done_o are 0.
- R2: Addresses are produced in this order: kernel column kx innermost, then kernel row ky, then channel, then output column outermost. The order advances by exactly one position on each cycle where out_valid_o and out_ready_i are both 1.
- R3: For a position inside the map, out_addr_o equals base + ((c·H + y)·W + x)·2 modulo 2^32. Here y = row·stride + ky − pad, x = col·stride + kx − pad, c is the absolute channel, and the element size is 2 bytes.
- R4: out_pad_o is 1 exactly when y < 0, y ≥ H, x < 0, x ≥ W, or c ≥ the channel count. While out_pad_o is 1, out_addr_o is 0.
- R5: While out_valid_o is 1 and out_ready_i is 0, the next cycle still shows out_valid_o at 1, with out_addr_o and out_pad_o unchanged.
- R6: done_o is 1 for exactly one cycle, the cycle after the final address is accepted. In that cycle out_valid_o is 0.
- R7: A start pulse while a tile is in progress is ignored. The running tile continues with its original configuration and sequence.
- R8: A start with a zero column count, zero channel count or zero kernel size emits no address and raises done_o in the next cycle.
- R9: Column and channel counts above 32 are treated as 32.
- R10: out_valid_o rises in the cycle after an accepted start, showing the first position (first column, first channel, ky = kx = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a tile using the cfg_* values (taken only when idle) |
| cfg_base_i | input | 32 | Byte address of channel 0, row 0, column 0 |
| cfg_height_i | input | 8 | Feature-map height H |
| cfg_width_i | input | 8 | Feature-map width W |
| cfg_chans_i | input | 8 | Channel count of the map |
| cfg_ksize_i | input | 3 | Kernel size K (K×K window) |
| cfg_stride_i | input | 3 | Stride |
| cfg_pad_i | input | 2 | Zero-padding on each border |
| cfg_out_row_i | input | 8 | Output row of the tile |
| cfg_col_first_i | input | 8 | First output column of the tile |
| cfg_col_count_i | input | 8 | Output columns in the tile (clamped to 32) |
| cfg_ch_first_i | input | 8 | First channel of the tile |
| cfg_ch_count_i | input | 8 | Channels in the tile (clamped to 32) |
| out_valid_o | output | 1 | Address valid |
| out_ready_i | input | 1 | Consumer accepts the address |
| out_addr_o | output | 32 | Source byte address (0 on padding) |
| out_pad_o | output | 1 | Position lies outside the map; supply zero |
| done_o | output | 1 | One-cycle pulse after the last accepted address |

## Verification
A corrupted nest counter shows at the ports in the very next accepted beat: the address steps by the wrong stride (2, 2·W or 2·H·W bytes), or the pad flag lands on the wrong kernel tap. The bench compares every beat against an independent model, so such faults surface within one handshake. An error in the wrap or last-beat logic shows up as done_o arriving early, late or not at all, or as out_valid_o staying high after the final beat. Both are checked on the exact cycle the tile should end. Stalls and a mid-tile start are mixed into the stream, so state that moves without a handshake shows up as a changed address during a stall or as a sequence that no longer matches the model.

// File: rtl/im2col_pkg.sv
package im2col_pkg;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

endpackage

// File: rtl/im2col_seq.sv
module im2col_seq
    import im2col_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DIM_W    = 8,
    parameter int KS_W     = 3,
    parameter int STR_W    = 3,
    parameter int PADV_W   = 2,
    parameter int MAX_TILE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic [DIM_W-1:0]  cfg_height_i,
    input  logic [DIM_W-1:0]  cfg_width_i,
    input  logic [DIM_W-1:0]  cfg_chans_i,
    input  logic [KS_W-1:0]   cfg_ksize_i,
    input  logic [STR_W-1:0]  cfg_stride_i,
    input  logic [PADV_W-1:0] cfg_pad_i,
    input  logic [DIM_W-1:0]  cfg_out_row_i,
    input  logic [DIM_W-1:0]  cfg_col_first_i,
    input  logic [DIM_W-1:0]  cfg_col_count_i,
    input  logic [DIM_W-1:0]  cfg_ch_first_i,
    input  logic [DIM_W-1:0]  cfg_ch_count_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [DIM_W-1:0]  height_o,
    output logic [DIM_W-1:0]  width_o,
    output logic [DIM_W-1:0]  chans_o,
    output logic [STR_W-1:0]  stride_o,
    output logic [PADV_W-1:0] pad_o,
    output logic [DIM_W-1:0]  row_o,
    output logic [DIM_W:0]    col_abs_o,
    output logic [DIM_W:0]    ch_abs_o,
    output logic [KS_W-1:0]   ky_o,
    output logic [KS_W-1:0]   kx_o
);

    localparam int TILE_W = $clog2(MAX_TILE + 1);
    localparam int IDX_W  = $clog2(MAX_TILE);
    localparam int ABS_W  = DIM_W + 1;

    typedef struct packed {
        gen_state_e        state;
        logic              done;
        logic [ADDR_W-1:0] base;
        logic [DIM_W-1:0]  height;
        logic [DIM_W-1:0]  width;
        logic [DIM_W-1:0]  chans;
        logic [KS_W-1:0]   ksize;
        logic [STR_W-1:0]  stride;
        logic [PADV_W-1:0] pad;
        logic [DIM_W-1:0]  row;
        logic [DIM_W-1:0]  col_first;
        logic [TILE_W-1:0] col_cnt;
        logic [DIM_W-1:0]  ch_first;
        logic [TILE_W-1:0] ch_cnt;
        logic [IDX_W-1:0]  col_idx;
        logic [IDX_W-1:0]  ch_idx;
        logic [KS_W-1:0]   ky;
        logic [KS_W-1:0]   kx;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [TILE_W-1:0] col_clamp;
    logic [TILE_W-1:0] ch_clamp;
    logic              kx_last, ky_last, ch_last, col_last;

    always_comb begin
        col_clamp = (cfg_col_count_i > DIM_W'(MAX_TILE)) ? TILE_W'(MAX_TILE)
                                                          : TILE_W'(cfg_col_count_i);
        ch_clamp  = (cfg_ch_count_i > DIM_W'(MAX_TILE))  ? TILE_W'(MAX_TILE)
                                                          : TILE_W'(cfg_ch_count_i);

        kx_last  = (st_q.kx == st_q.ksize - KS_W'(1));
        ky_last  = (st_q.ky == st_q.ksize - KS_W'(1));
        ch_last  = (TILE_W'(st_q.ch_idx) == st_q.ch_cnt - TILE_W'(1));
        col_last = (TILE_W'(st_q.col_idx) == st_q.col_cnt - TILE_W'(1));

        st_d      = st_q;
        st_d.done = 1'b0;

        if (st_q.state == GEN_IDLE) begin
            if (start_i) begin
                st_d.base      = cfg_base_i;
                st_d.height    = cfg_height_i;
                st_d.width     = cfg_width_i;
                st_d.chans     = cfg_chans_i;
                st_d.ksize     = cfg_ksize_i;
                st_d.stride    = cfg_stride_i;
                st_d.pad       = cfg_pad_i;
                st_d.row       = cfg_out_row_i;
                st_d.col_first = cfg_col_first_i;
                st_d.col_cnt   = col_clamp;
                st_d.ch_first  = cfg_ch_first_i;
                st_d.ch_cnt    = ch_clamp;
                st_d.col_idx   = '0;
                st_d.ch_idx    = '0;
                st_d.ky        = '0;
                st_d.kx        = '0;
                if (col_clamp == '0 || ch_clamp == '0 || cfg_ksize_i == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.state = GEN_RUN;
                end
            end
        end else if (ready_i) begin
            if (!kx_last) begin
                st_d.kx = st_q.kx + KS_W'(1);
            end else begin
                st_d.kx = '0;
                if (!ky_last) begin
                    st_d.ky = st_q.ky + KS_W'(1);
                end else begin
                    st_d.ky = '0;
                    if (!ch_last) begin
                        st_d.ch_idx = st_q.ch_idx + IDX_W'(1);
                    end else begin
                        st_d.ch_idx = '0;
                        if (!col_last) begin
                            st_d.col_idx = st_q.col_idx + IDX_W'(1);
                        end else begin
                            st_d.col_idx = '0;
                            st_d.state   = GEN_IDLE;
                            st_d.done    = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o   = (st_q.state == GEN_RUN);
    assign done_o    = st_q.done;
    assign base_o    = st_q.base;
    assign height_o  = st_q.height;
    assign width_o   = st_q.width;
    assign chans_o   = st_q.chans;
    assign stride_o  = st_q.stride;
    assign pad_o     = st_q.pad;
    assign row_o     = st_q.row;
    assign col_abs_o = ABS_W'(st_q.col_first) + ABS_W'(st_q.col_idx);
    assign ch_abs_o  = ABS_W'(st_q.ch_first) + ABS_W'(st_q.ch_idx);
    assign ky_o      = st_q.ky;
    assign kx_o      = st_q.kx;

endmodule

// File: rtl/im2col_addr_calc.sv
module im2col_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int DIM_W      = 8,
    parameter int KS_W       = 3,
    parameter int STR_W      = 3,
    parameter int PADV_W     = 2,
    parameter int ELEM_BYTES = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DIM_W-1:0]  height_i,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  chans_i,
    input  logic [STR_W-1:0]  stride_i,
    input  logic [PADV_W-1:0] pad_i,
    input  logic [DIM_W-1:0]  row_i,
    input  logic [DIM_W:0]    col_abs_i,
    input  logic [DIM_W:0]    ch_abs_i,
    input  logic [KS_W-1:0]   ky_i,
    input  logic [KS_W-1:0]   kx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              pad_o
);

    localparam int  COORD_W    = DIM_W + STR_W + KS_W + 1;
    localparam int  ABS_W      = DIM_W + 1;
    localparam bit  ELEM_POW2  = ((ELEM_BYTES & (ELEM_BYTES - 1)) == 0);
    localparam int  ELEM_SHIFT = $clog2(ELEM_BYTES);

    logic [COORD_W-1:0] y_pos, x_pos, y_val, x_val;
    logic               y_out, x_out, c_out;
    logic [ADDR_W-1:0]  lin;
    logic [ADDR_W-1:0]  scaled;

    always_comb begin
        y_pos = COORD_W'(row_i) * COORD_W'(stride_i) + COORD_W'(ky_i);
        x_pos = COORD_W'(col_abs_i) * COORD_W'(stride_i) + COORD_W'(kx_i);
        y_val = y_pos - COORD_W'(pad_i);
        x_val = x_pos - COORD_W'(pad_i);
        y_out = (y_pos < COORD_W'(pad_i)) || (y_val >= COORD_W'(height_i));
        x_out = (x_pos < COORD_W'(pad_i)) || (x_val >= COORD_W'(width_i));
        c_out = (ch_abs_i >= ABS_W'(chans_i));
        lin   = (ADDR_W'(ch_abs_i) * ADDR_W'(height_i) + ADDR_W'(y_val))
                * ADDR_W'(width_i) + ADDR_W'(x_val);
    end

    generate
        if (ELEM_POW2) begin : g_shift
            assign scaled = lin << ELEM_SHIFT;
        end else begin : g_mult
            assign scaled = lin * ADDR_W'(ELEM_BYTES);
        end
    endgenerate

    assign pad_o  = y_out || x_out || c_out;
    assign addr_o = pad_o ? '0 : base_i + scaled;

endmodule

// File: rtl/im2col_addr_gen.sv
module im2col_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int DIM_W      = 8,
    parameter int KS_W       = 3,
    parameter int STR_W      = 3,
    parameter int PADV_W     = 2,
    parameter int MAX_TILE   = 32,
    parameter int ELEM_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic [DIM_W-1:0]  cfg_height_i,
    input  logic [DIM_W-1:0]  cfg_width_i,
    input  logic [DIM_W-1:0]  cfg_chans_i,
    input  logic [KS_W-1:0]   cfg_ksize_i,
    input  logic [STR_W-1:0]  cfg_stride_i,
    input  logic [PADV_W-1:0] cfg_pad_i,
    input  logic [DIM_W-1:0]  cfg_out_row_i,
    input  logic [DIM_W-1:0]  cfg_col_first_i,
    input  logic [DIM_W-1:0]  cfg_col_count_i,
    input  logic [DIM_W-1:0]  cfg_ch_first_i,
    input  logic [DIM_W-1:0]  cfg_ch_count_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [ADDR_W-1:0] out_addr_o,
    output logic              out_pad_o,
    output logic              done_o
);

    logic [ADDR_W-1:0] base_w;
    logic [DIM_W-1:0]  height_w, width_w, chans_w, row_w;
    logic [STR_W-1:0]  stride_w;
    logic [PADV_W-1:0] pad_w;
    logic [DIM_W:0]    col_abs_w, ch_abs_w;
    logic [KS_W-1:0]   ky_w, kx_w;

    im2col_seq #(
        .ADDR_W  (ADDR_W),
        .DIM_W   (DIM_W),
        .KS_W    (KS_W),
        .STR_W   (STR_W),
        .PADV_W  (PADV_W),
        .MAX_TILE(MAX_TILE)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .cfg_base_i     (cfg_base_i),
        .cfg_height_i   (cfg_height_i),
        .cfg_width_i    (cfg_width_i),
        .cfg_chans_i    (cfg_chans_i),
        .cfg_ksize_i    (cfg_ksize_i),
        .cfg_stride_i   (cfg_stride_i),
        .cfg_pad_i      (cfg_pad_i),
        .cfg_out_row_i  (cfg_out_row_i),
        .cfg_col_first_i(cfg_col_first_i),
        .cfg_col_count_i(cfg_col_count_i),
        .cfg_ch_first_i (cfg_ch_first_i),
        .cfg_ch_count_i (cfg_ch_count_i),
        .ready_i        (out_ready_i),
        .valid_o        (out_valid_o),
        .done_o         (done_o),
        .base_o         (base_w),
        .height_o       (height_w),
        .width_o        (width_w),
        .chans_o        (chans_w),
        .stride_o       (stride_w),
        .pad_o          (pad_w),
        .row_o          (row_w),
        .col_abs_o      (col_abs_w),
        .ch_abs_o       (ch_abs_w),
        .ky_o           (ky_w),
        .kx_o           (kx_w)
    );

    im2col_addr_calc #(
        .ADDR_W    (ADDR_W),
        .DIM_W     (DIM_W),
        .KS_W      (KS_W),
        .STR_W     (STR_W),
        .PADV_W    (PADV_W),
        .ELEM_BYTES(ELEM_BYTES)
    ) u_calc (
        .base_i   (base_w),
        .height_i (height_w),
        .width_i  (width_w),
        .chans_i  (chans_w),
        .stride_i (stride_w),
        .pad_i    (pad_w),
        .row_i    (row_w),
        .col_abs_i(col_abs_w),
        .ch_abs_i (ch_abs_w),
        .ky_i     (ky_w),
        .kx_i     (kx_w),
        .addr_o   (out_addr_o),
        .pad_o    (out_pad_o)
    );

endmodule

// File: rtl/im2col_addr_gen_chk.sv
module im2col_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              out_ready_i,
    input logic              out_valid_o,
    input logic [ADDR_W-1:0] out_addr_o,
    input logic              out_pad_o,
    input logic              done_o
);

    // R5: a stalled beat is held unchanged
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o) && $stable(out_pad_o)))
        else $error("a_r5_stall_hold");

    // R6: done only while no address is offered
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !out_valid_o)
        else $error("a_r6_done_idle");

    // R6 / R8: done follows an accepted beat or a start
    a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(out_valid_o && out_ready_i) || $past(start_i)))
        else $error("a_r6_done_cause");

    // R6: done lasts a single cycle unless a new empty job starts
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o)
        else $error("a_r6_done_pulse");

    // R10: valid rises only after a start
    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> $past(start_i))
        else $error("a_r10_valid_rise");

endmodule

bind im2col_addr_gen im2col_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o),
    .out_addr_o (out_addr_o),
    .out_pad_o  (out_pad_o),
    .done_o     (done_o)
);

// File: tb/im2col_addr_gen_tb.sv
`timescale 1ns/1ps
module im2col_addr_gen_tb;

    typedef struct packed {
        logic [31:0] base;
        logic [7:0]  h;
        logic [7:0]  w;
        logic [7:0]  chans;
        logic [2:0]  k;
        logic [2:0]  s;
        logic [1:0]  p;
        logic [7:0]  row;
        logic [7:0]  col0;
        logic [7:0]  ncol;
        logic [7:0]  ch0;
        logic [7:0]  nch;
        logic [7:0]  stall;
        logic [7:0]  garb;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 8'd5, 8'd5, 8'd2, 3'd3, 3'd1, 2'd1, 8'd0, 8'd0, 8'd2,  8'd0, 8'd2, 8'd0, 8'd255},
        '{32'h0000_2000, 8'd6, 8'd7, 8'd3, 3'd3, 3'd2, 2'd0, 8'd2, 8'd1, 8'd3,  8'd1, 8'd2, 8'd3, 8'd4},
        '{32'h0000_0000, 8'd4, 8'd4, 8'd1, 3'd3, 3'd1, 2'd1, 8'd3, 8'd2, 8'd3,  8'd0, 8'd2, 8'd2, 8'd255},
        '{32'h0000_0100, 8'd8, 8'd8, 8'd4, 3'd1, 3'd1, 2'd0, 8'd7, 8'd0, 8'd40, 8'd3, 8'd1, 8'd0, 8'd255},
        '{32'h0000_0040, 8'd9, 8'd9, 8'd2, 3'd5, 3'd3, 2'd2, 8'd1, 8'd0, 8'd2,  8'd0, 8'd2, 8'd5, 8'd10},
        '{32'hFFFF_FF00, 8'd3, 8'd5, 8'd2, 3'd2, 3'd1, 2'd0, 8'd1, 8'd3, 8'd2,  8'd1, 8'd1, 8'd0, 8'd255}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ready = 1'b1;
    vec_t        cfg = '0;
    logic        valid, pad, done;
    logic [31:0] addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    im2col_addr_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .cfg_base_i     (cfg.base),
        .cfg_height_i   (cfg.h),
        .cfg_width_i    (cfg.w),
        .cfg_chans_i    (cfg.chans),
        .cfg_ksize_i    (cfg.k),
        .cfg_stride_i   (cfg.s),
        .cfg_pad_i      (cfg.p),
        .cfg_out_row_i  (cfg.row),
        .cfg_col_first_i(cfg.col0),
        .cfg_col_count_i(cfg.ncol),
        .cfg_ch_first_i (cfg.ch0),
        .cfg_ch_count_i (cfg.nch),
        .out_valid_o    (valid),
        .out_ready_i    (ready),
        .out_addr_o     (addr),
        .out_pad_o      (pad),
        .done_o         (done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int clamp32(input int n);
        return (n > 32) ? 32 : n;
    endfunction

    // independent reference for R3 / R4
    task automatic model(input vec_t v, input int oi, input int ci, input int ky, input int kx,
                         output logic [31:0] ea, output logic ep);
        int y, x, c;
        y  = int'(v.row) * int'(v.s) + ky - int'(v.p);
        x  = (int'(v.col0) + oi) * int'(v.s) + kx - int'(v.p);
        c  = int'(v.ch0) + ci;
        ep = (y < 0) || (y >= int'(v.h)) || (x < 0) || (x >= int'(v.w)) || (c >= int'(v.chans));
        ea = ep ? 32'h0 : v.base + 32'((c * int'(v.h) + y) * int'(v.w) + x) * 32'd2;
    endtask

    task automatic run_vec(input vec_t v);
        int          n;
        logic [31:0] ea;
        logic        ep;
        logic [31:0] held_a;
        logic        held_p;
        cfg   = v;
        start = 1'b1;
        ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 valid after start", 32'(valid), 32'd1);
        n = 0;
        for (int oi = 0; oi < clamp32(int'(v.ncol)); oi++) begin
            for (int ci = 0; ci < clamp32(int'(v.nch)); ci++) begin
                for (int ky = 0; ky < int'(v.k); ky++) begin
                    for (int kx = 0; kx < int'(v.k); kx++) begin
                        model(v, oi, ci, ky, kx, ea, ep);
                        if (v.stall != 0 && (n % int'(v.stall)) == 1) begin
                            ready  = 1'b0;
                            held_a = addr;
                            held_p = pad;
                            @(negedge clk);
                            check("R5 stall valid", 32'(valid), 32'd1);
                            check("R5 stall addr", addr, held_a);
                            check("R5 stall pad", 32'(pad), 32'(held_p));
                            ready = 1'b1;
                        end
                        if (n == int'(v.garb)) begin
                            // R7: start while busy with a different job
                            cfg   = '{32'h00AB_0000, 8'd2, 8'd2, 8'd1, 3'd1, 3'd1, 2'd0,
                                      8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255};
                            start = 1'b1;
                        end
                        check("R2 valid", 32'(valid), 32'd1);
                        check("R4 pad", 32'(pad), 32'(ep));
                        check("R3 addr", addr, ea);
                        @(negedge clk);
                        if (start) begin
                            start = 1'b0;
                            cfg   = v;
                            check("R7 start ignored, done low", 32'(done), 32'd0);
                        end
                        n++;
                    end
                end
            end
        end
        check("R6 done after last", 32'(done), 32'd1);
        check("R6 valid low with done", 32'(valid), 32'd0);
        @(negedge clk);
        check("R6 done single pulse", 32'(done), 32'd0);
    endtask

    task automatic run_empty(input vec_t v, input string req);
        cfg   = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req, 32'(valid), 32'd0);
        check(req, 32'(done), 32'd1);
        @(negedge clk);
        check(req, 32'(done), 32'd0);
        check(req, 32'(valid), 32'd0);
    endtask

    initial begin
        vec_t e;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(valid), 32'd0);
        check("R1 done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(valid), 32'd0);
        check("R1 done after reset", 32'(done), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
            @(negedge clk);
        end

        // R8: empty jobs
        e = VECS[0];
        e.ncol = 8'd0;
        run_empty(e, "R8 zero columns");
        e = VECS[0];
        e.nch = 8'd0;
        run_empty(e, "R8 zero channels");
        e = VECS[0];
        e.k = 3'd0;
        run_empty(e, "R8 zero kernel");

        // R9: channel clamp, 1x1 kernel, 40 channels requested
        e = '{32'h0000_0000, 8'd1, 8'd1, 8'd64, 3'd1, 3'd1, 2'd0,
              8'd0, 8'd0, 8'd1, 8'd0, 8'd40, 8'd0, 8'd255};
        run_vec(e);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule